// File: doc/BRIEF.md
# Switchable Bit-Stuffing Remover for a Serial Receive Path

This block sits in a bit-serial receive path behind a line deframer. Each cycle it may be handed one received bit, marked by a bit-valid strobe. When the destuff control is on, it counts consecutive 1s. A 0 that arrives after exactly five 1s was inserted by the far-end transmitter so that payload can never look like a flag or an abort, and the block deletes it. A 0 that follows six or more 1s belongs to a real flag, so it is passed on unchanged. When the control is off, every bit goes through untouched.

The output is the same bit one clock later, with its own valid strobe. The strobe stays low for a deleted bit, so downstream byte assembly never sees the stuffed zero. Two pulse outputs mark a flag ending (a 0 after exactly six 1s) and an abort (the seventh 1 in a row). The downstream receiver uses them for frame delimiting and error handling. Both detectors work whether or not destuffing is enabled.

Top module: `hdlc_destuff`

## Requirements
- R1: While and after reset, out_valid, out_bit, flag_det and abort_det are all 0.
- R2: With destuff_en=1, a valid 0 that follows exactly five consecutive valid 1s produces no out_valid pulse one clock later.
- R3: With destuff_en=1, a valid 0 that follows six or more consecutive valid 1s is passed: out_valid=1 and out_bit=0 one clock later.
- R4: With destuff_en=0, every valid input bit is passed, including a 0 after exactly five 1s.
- R5: Every passed bit appears on out_bit with out_valid=1 exactly one clock after the cycle in which in_valid=1 presented it.
- R6: A cycle with in_valid=0 gives out_valid=0 one clock later and leaves the count of consecutive 1s unchanged.
- R7: A valid 0 following exactly six consecutive 1s pulses flag_det for one clock, in the same cycle in which that 0 is output.
- R8: The seventh consecutive valid 1 pulses abort_det for one clock. Further 1s in the same run give no further pulse.
- R9: Any valid 0 clears the count of 1s. A 0 after fewer than five 1s is always passed.
- R10: flag_det and abort_det behave the same with destuff_en=0 as with destuff_en=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| destuff_en | input | 1 | 1 = delete stuffed zeros, 0 = pass every bit |
| in_bit | input | 1 | Received serial data bit |
| in_valid | input | 1 | in_bit is valid this cycle |
| out_bit | output | 1 | Data bit, delayed by one clock |
| out_valid | output | 1 | out_bit is a delivered bit |
| flag_det | output | 1 | One-clock pulse: 0 after exactly six 1s |
| abort_det | output | 1 | One-clock pulse: seventh consecutive 1 |

## Verification
The bench drives zeros that end runs of four, five, six and seven or more 1s. These separate three cases: a deleted stuffed bit, a passed flag bit, and a passed bit after a run that was cleared early. It then repeats the five-ones run with destuffing disabled, which shows that the control gates only the deletion and not the detectors. Idle gaps placed inside a run of 1s show that non-valid cycles neither break nor extend the run. A mid-stream reset shows that a partial run is forgotten.

// File: rtl/destuff_pkg.sv
package destuff_pkg;

  // Next value of the consecutive-ones count after one valid bit.
  function automatic int unsigned ones_next(input int unsigned run,
                                            input logic b,
                                            input int unsigned sat);
    if (!b) return 0;
    return (run >= sat) ? sat : run + 1;
  endfunction

  // True when a valid bit is a stuffed zero that must be deleted.
  function automatic logic is_stuffed(input int unsigned run, input logic b,
                                      input logic en, input int unsigned lim);
    return en && !b && (run == lim);
  endfunction

endpackage

// File: rtl/destuff_run_ctr.sv
module destuff_run_ctr #(
  parameter int unsigned SAT   = 7,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_bit,
  output logic [CNT_W-1:0] run_q
);
  import destuff_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)
      run_q <= '0;
    else if (in_valid)
      run_q <= CNT_W'(ones_next(32'(run_q), in_bit, SAT));
  end
endmodule

// File: rtl/destuff_classify.sv
module destuff_classify #(
  parameter int unsigned STUFF_RUN = 5,
  parameter int unsigned CNT_W     = 3
) (
  input  logic             in_valid,
  input  logic             in_bit,
  input  logic             destuff_en,
  input  logic [CNT_W-1:0] run_q,
  output logic             drop_evt,
  output logic             flag_evt,
  output logic             abort_evt
);
  import destuff_pkg::*;
  localparam int unsigned FLAG_RUN = STUFF_RUN + 1;

  always_comb begin
    drop_evt  = in_valid && is_stuffed(32'(run_q), in_bit, destuff_en, STUFF_RUN);
    flag_evt  = in_valid && !in_bit && (32'(run_q) == FLAG_RUN);
    abort_evt = in_valid && in_bit && (32'(run_q) == FLAG_RUN);
  end
endmodule

// File: rtl/destuff_out_reg.sv
module destuff_out_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  input  logic drop_evt,
  input  logic flag_evt,
  input  logic abort_evt,
  output logic out_bit,
  output logic out_valid,
  output logic flag_det,
  output logic abort_det
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_bit   <= 1'b0;
      out_valid <= 1'b0;
      flag_det  <= 1'b0;
      abort_det <= 1'b0;
    end else begin
      out_bit   <= in_valid ? in_bit : 1'b0;
      out_valid <= in_valid && !drop_evt;
      flag_det  <= flag_evt;
      abort_det <= abort_evt;
    end
  end
endmodule

// File: rtl/hdlc_destuff.sv
module hdlc_destuff #(
  parameter int unsigned STUFF_RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic destuff_en,
  input  logic in_bit,
  input  logic in_valid,
  output logic out_bit,
  output logic out_valid,
  output logic flag_det,
  output logic abort_det
);
  localparam int unsigned SAT   = STUFF_RUN + 2;
  localparam int unsigned CNT_W = $clog2(SAT + 1);

  logic [CNT_W-1:0] run_q;
  logic drop_evt, flag_evt, abort_evt;

  destuff_run_ctr #(.SAT(SAT), .CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit), .run_q(run_q)
  );

  destuff_classify #(.STUFF_RUN(STUFF_RUN), .CNT_W(CNT_W)) u_cls (
    .in_valid(in_valid), .in_bit(in_bit), .destuff_en(destuff_en), .run_q(run_q),
    .drop_evt(drop_evt), .flag_evt(flag_evt), .abort_evt(abort_evt)
  );

  destuff_out_reg u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .drop_evt(drop_evt), .flag_evt(flag_evt), .abort_evt(abort_evt),
    .out_bit(out_bit), .out_valid(out_valid), .flag_det(flag_det), .abort_det(abort_det)
  );
endmodule

// File: rtl/hdlc_destuff_chk.sv
module hdlc_destuff_chk #(
  parameter int unsigned STUFF_RUN = 5,
  parameter int unsigned CNT_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             destuff_en,
  input logic             in_bit,
  input logic             in_valid,
  input logic             out_bit,
  input logic             out_valid,
  input logic             flag_det,
  input logic             abort_det,
  input logic [CNT_W-1:0] run_q
);
  localparam logic [CNT_W-1:0] STUFF_C = CNT_W'(STUFF_RUN);
  localparam logic [CNT_W-1:0] SAT_C   = CNT_W'(STUFF_RUN + 2);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !flag_det && !abort_det);

  assert_stuffed_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && destuff_en && !in_bit && run_q == STUFF_C |=> !out_valid);

  assert_pass_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !destuff_en |=> out_valid && out_bit == $past(in_bit));

  assert_one_clock_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_bit |=> out_valid && out_bit);

  assert_idle_no_output_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(run_q));

  assert_flag_with_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_det |-> out_valid && !out_bit);

  assert_abort_on_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_det |-> out_valid && out_bit && run_q == SAT_C);

  assert_zero_clears_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_bit |=> run_q == '0);

  assert_run_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= SAT_C);

  assert_events_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_det, abort_det}));
endmodule

bind hdlc_destuff hdlc_destuff_chk #(.STUFF_RUN(STUFF_RUN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .destuff_en(destuff_en), .in_bit(in_bit),
  .in_valid(in_valid), .out_bit(out_bit), .out_valid(out_valid),
  .flag_det(flag_det), .abort_det(abort_det), .run_q(run_q)
);

// File: tb/sim_hdlc_destuff.sv
module sim_hdlc_destuff;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 40;
  // Entry: {req[3:0], en, bit, exp_valid, exp_bit, exp_flag, exp_abort}
  localparam logic [9:0] VEC [NVEC] = '{
    {4'd5, 6'b11_11_00}, {4'd5, 6'b11_11_00}, {4'd5, 6'b11_11_00},
    {4'd5, 6'b11_11_00}, {4'd5, 6'b11_11_00},
    {4'd2, 6'b10_00_00},                       // R2 stuffed zero removed
    {4'd9, 6'b10_10_00},                       // R9 zero after no ones
    {4'd5, 6'b11_11_00}, {4'd5, 6'b11_11_00}, {4'd5, 6'b11_11_00},
    {4'd5, 6'b11_11_00}, {4'd5, 6'b11_11_00}, {4'd5, 6'b11_11_00},
    {4'd7, 6'b10_10_10},                       // R7 flag end, zero kept
    {4'd5, 6'b11_11_00}, {4'd5, 6'b11_11_00}, {4'd5, 6'b11_11_00},
    {4'd5, 6'b11_11_00}, {4'd5, 6'b11_11_00}, {4'd5, 6'b11_11_00},
    {4'd8, 6'b11_11_01},                       // R8 seventh one
    {4'd8, 6'b11_11_00},                       // R8 no second pulse
    {4'd3, 6'b10_10_00},                       // R3 zero after 8 ones kept
    {4'd4, 6'b01_11_00}, {4'd4, 6'b01_11_00}, {4'd4, 6'b01_11_00},
    {4'd4, 6'b01_11_00}, {4'd4, 6'b01_11_00},
    {4'd4, 6'b00_10_00},                       // R4 disabled: zero kept
    {4'd9, 6'b11_11_00}, {4'd9, 6'b11_11_00}, {4'd9, 6'b11_11_00},
    {4'd9, 6'b11_11_00},
    {4'd9, 6'b10_10_00},                       // R9 zero after four ones
    {4'd2, 6'b11_11_00}, {4'd2, 6'b11_11_00}, {4'd2, 6'b11_11_00},
    {4'd2, 6'b11_11_00}, {4'd2, 6'b11_11_00},
    {4'd2, 6'b10_00_00}                        // R2 again after clean restart
  };

  logic clk = 1'b0, rst_n = 1'b0, destuff_en = 1'b0, in_bit = 1'b0, in_valid = 1'b0;
  logic out_bit, out_valid, flag_det, abort_det;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_destuff u0 (
    .clk(clk), .rst_n(rst_n), .destuff_en(destuff_en), .in_bit(in_bit),
    .in_valid(in_valid), .out_bit(out_bit), .out_valid(out_valid),
    .flag_det(flag_det), .abort_det(abort_det)
  );

  task automatic check(input int req, input logic [3:0] exp);
    logic [3:0] act;
    act = {out_valid, out_bit, flag_det, abort_det};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: {valid,bit,flag,abort} actual %b expected %b", req, act, exp);
    end
  endtask

  // Present one input for one cycle, then sample the registered result.
  task automatic step(input logic en, input logic v, input logic b,
                      input int req, input logic [3:0] exp);
    @(negedge clk);
    destuff_en = en; in_valid = v; in_bit = b;
    @(posedge clk); #1;
    check(req, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check(1, 4'b0000);                         // R1 outputs quiet in reset
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++)
      step(VEC[i][5], 1'b1, VEC[i][4], int'(VEC[i][9:6]), VEC[i][3:0]);

    // R6: idle gaps inside a run neither break nor extend it
    step(1'b1, 1'b0, 1'b1, 6, 4'b0000);
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 1'b1, 1'b1, 6, 4'b1100);
      step(1'b1, 1'b0, 1'b0, 6, 4'b0000);
    end
    step(1'b1, 1'b1, 1'b0, 6, 4'b0000);           // R6 still stuffed after gaps

    // R10: detectors active with destuffing off
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b1, 10, 4'b1100);
    step(1'b0, 1'b1, 1'b0, 10, 4'b1010);          // R10 flag pulse
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b1, 10, 4'b1100);
    step(1'b0, 1'b1, 1'b1, 10, 4'b1101);          // R10 abort pulse
    step(1'b0, 1'b1, 1'b0, 10, 4'b1000);

    // R1: mid-run reset forgets a partial run
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1, 4'b1100);
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
    @(posedge clk); #1 check(1, 4'b0000);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1, 4'b1100);
    step(1'b1, 1'b1, 1'b0, 1, 4'b1000);           // R1 only 3 ones since reset
    step(1'b1, 1'b0, 1'b0, 6, 4'b0000);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule